// File: doc/BRIEF.md
# Transition-Triggered Read Sense Sequencer

This block models, at clock-cycle granularity, a memory read path that does not sense its array continuously. A sense operation starts only when new data is requested: when the sampled chip enable goes from inactive to active, or when any address bit differs from the previous cycle while chip enable is active. Requests that arrive close together are folded into one sense pulse of fixed length. When the pulse completes, the array word is captured into an output register, which then holds its value until the next request, even if the stored word behind it changes.

A request that comes after the merge window has closed, while a sense is still running, models input skew that is too large. It aborts the running sense, restarts the pulse count from one and sets a sticky hazard flag that software-visible logic, or the surrounding model, clears with a dedicated input. The data-drive enable follows the usual asynchronous memory rule: drive only when selected, output-enabled and not writing. The storage array sits outside the block. It presents the word for the current address on `arr_data_i`.

Top module: `read_sense_seq`

## Requirements
- R1: While `rst_ni` is low, `dout_o`, `upd_o`, `sense_o` and `hazard_o` are all 0.
- R2: A rising chip enable (`chip_en_i` 1 this cycle, 0 the cycle before) starts a sense. `sense_o` is high for exactly SENSE_CYC cycles, beginning the cycle after the request.
- R3: An address change (any bit of `addr_i` differs from the previous cycle) starts a sense only while `chip_en_i` is 1. With `chip_en_i` at 0, address changes leave `sense_o` low.
- R4: At the clock edge that ends the last sense cycle, `dout_o` loads `arr_data_i`. `upd_o` is high for exactly the one following cycle, in which the new word is already on `dout_o`.
- R5: A request seen while the sense count is 1..MERGE_CYC is merged. It neither lengthens the pulse nor adds an update, and it leaves `hazard_o` unchanged.
- R6: A request seen while the sense count is above MERGE_CYC restarts the count at 1 without loading data, and it sets `hazard_o`.
- R7: `hazard_o` stays set until `hazard_clr_i` is sampled high. A restart in the same cycle as a clear leaves it set.
- R8: Without a new request, `dout_o` keeps its value even when `arr_data_i` changes.
- R9: `dout_oe_o` is 1 only when `chip_en_i` is 1, `out_en_i` is 1 and `wr_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_en_i | input | 1 | Sampled chip select, active high |
| out_en_i | input | 1 | Output enable, active high |
| wr_en_i | input | 1 | Write in progress, active high |
| addr_i | input | AW | Word address |
| arr_data_i | input | DW | Array word at the current address |
| hazard_clr_i | input | 1 | Clears the sticky hazard flag |
| dout_o | output | DW | Held read data |
| dout_oe_o | output | 1 | Data drive enable |
| upd_o | output | 1 | One-cycle strobe: `dout_o` has just been reloaded |
| sense_o | output | 1 | Sense pulse active |
| hazard_o | output | 1 | Sticky late-trigger flag |

## Verification
A request seen at clock edge k raises `sense_o` right after that edge. `dout_o` and `upd_o` change right after edge k+SENSE_CYC, and `upd_o` drops after edge k+SENSE_CYC+1. A late request or a clear acts on `hazard_o` right after the edge that samples it, while `dout_oe_o` follows its inputs in the same cycle. The bench drives inputs just after the falling edge. It advances a behavioural model on each rising edge and compares every output at the next falling edge, so each result is checked in exactly the cycle it is due. Directed checks count update strobes over merge and restart episodes.

// File: rtl/read_sense_pkg.sv
package read_sense_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_START = 2'd1,
    EV_MERGE = 2'd2,
    EV_LATE  = 2'd3
  } sense_evt_e;
endpackage

// File: rtl/rsq_trig_det.sv
module rsq_trig_det #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          chip_en_i,
  input  logic [AW-1:0] addr_i,
  output logic          req_o
);
  logic          ce_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] bit_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      ce_q   <= chip_en_i;
      addr_q <= addr_i;
    end
  end

  for (genvar b = 0; b < AW; b++) begin : g_bit
    assign bit_chg[b] = addr_i[b] ^ addr_q[b];
  end

  assign req_o = chip_en_i & (~ce_q | (|bit_chg));
endmodule

// File: rtl/rsq_sense_ctl.sv
module rsq_sense_ctl
  import read_sense_pkg::*;
#(
  parameter int SENSE_CYC = 5,
  parameter int MERGE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic sense_o,
  output logic done_o,
  output logic late_o
);
  localparam int CW = $clog2(SENSE_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST  = CW'(SENSE_CYC);
  localparam logic [CW-1:0] CNT_MERGE = CW'(MERGE_CYC);
  localparam logic [CW-1:0] CNT_ONE   = CW'(1);

  sense_evt_e    evt;
  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    evt = EV_NONE;
    if (!busy_q) begin
      if (req_i) evt = EV_START;
    end else if (req_i) begin
      evt = (cnt_q > CNT_MERGE) ? EV_LATE : EV_MERGE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      unique case (evt)
        EV_START, EV_LATE: begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_ONE;
        end
        default: begin
          if (busy_q) begin
            if (cnt_q == CNT_LAST) begin
              busy_q <= 1'b0;
              cnt_q  <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_ONE;
            end
          end
        end
      endcase
    end
  end

  assign sense_o = busy_q;
  assign late_o  = (evt == EV_LATE);
  assign done_o  = busy_q & (cnt_q == CNT_LAST) & (evt != EV_LATE);
endmodule

// File: rtl/rsq_out_hold.sv
module rsq_out_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          haz_set_i,
  input  logic          haz_clr_i,
  output logic [DW-1:0] dout_o,
  output logic          upd_o,
  output logic          hazard_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o   <= '0;
      upd_o    <= 1'b0;
      hazard_o <= 1'b0;
    end else begin
      upd_o <= load_i;
      if (load_i) dout_o <= data_i;
      // set wins over clear
      if (haz_set_i)      hazard_o <= 1'b1;
      else if (haz_clr_i) hazard_o <= 1'b0;
    end
  end
endmodule

// File: rtl/read_sense_seq.sv
module read_sense_seq #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int SENSE_CYC = 5,
  parameter int MERGE_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          chip_en_i,
  input  logic          out_en_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] arr_data_i,
  input  logic          hazard_clr_i,
  output logic [DW-1:0] dout_o,
  output logic          dout_oe_o,
  output logic          upd_o,
  output logic          sense_o,
  output logic          hazard_o
);
  logic req, done, late;

  rsq_trig_det #(.AW(AW)) u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .chip_en_i(chip_en_i),
    .addr_i   (addr_i),
    .req_o    (req)
  );

  rsq_sense_ctl #(.SENSE_CYC(SENSE_CYC), .MERGE_CYC(MERGE_CYC)) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .sense_o(sense_o),
    .done_o (done),
    .late_o (late)
  );

  rsq_out_hold #(.DW(DW)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (done),
    .data_i   (arr_data_i),
    .haz_set_i(late),
    .haz_clr_i(hazard_clr_i),
    .dout_o   (dout_o),
    .upd_o    (upd_o),
    .hazard_o (hazard_o)
  );

  assign dout_oe_o = chip_en_i & out_en_i & ~wr_en_i;
endmodule

// File: rtl/read_sense_chk.sv
module read_sense_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          chip_en_i,
  input logic          out_en_i,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic          hazard_clr_i,
  input logic [DW-1:0] dout_o,
  input logic          dout_oe_o,
  input logic          upd_o,
  input logic          sense_o,
  input logic          hazard_o
);
  a_r4_upd_after_sense: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(upd_o) |-> $past(sense_o));

  a_r4_upd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  a_r8_dout_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> $stable(dout_o));

  a_r3_no_start_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sense_o && !chip_en_i) |=> !sense_o);

  a_r7_haz_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hazard_o && !hazard_clr_i) |=> hazard_o);

  a_r6_haz_needs_sense: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hazard_o) |-> $past(sense_o));

  a_r9_no_drive_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i || !chip_en_i || !out_en_i) |-> !dout_oe_o);
endmodule

bind read_sense_seq read_sense_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chip_en_i   (chip_en_i),
  .out_en_i    (out_en_i),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .hazard_clr_i(hazard_clr_i),
  .dout_o      (dout_o),
  .dout_oe_o   (dout_oe_o),
  .upd_o       (upd_o),
  .sense_o     (sense_o),
  .hazard_o    (hazard_o)
);

// File: tb/read_sense_seq_test.sv
module read_sense_seq_test;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int SC = 5;
  localparam int MC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b0, oe = 1'b0, we = 1'b0, clr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] arr_data;
  logic [DW-1:0] dout;
  logic          doe, upd, sense, haz;

  int checks = 0;
  int errors = 0;
  int upd_seen = 0;

  always #5 clk = ~clk;
  assign arr_data = mem[addr];

  read_sense_seq #(.AW(AW), .DW(DW), .SENSE_CYC(SC), .MERGE_CYC(MC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .chip_en_i(ce), .out_en_i(oe), .wr_en_i(we),
    .addr_i(addr), .arr_data_i(arr_data), .hazard_clr_i(clr),
    .dout_o(dout), .dout_oe_o(doe), .upd_o(upd), .sense_o(sense), .hazard_o(haz)
  );

  // behavioural reference
  logic [DW-1:0] m_dout;
  bit m_upd, m_act, m_haz, m_pce;
  logic [AW-1:0] m_paddr;
  int m_el;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dout = '0; m_upd = 0; m_act = 0; m_haz = 0; m_pce = 0; m_paddr = '0; m_el = 0;
    end else begin
      bit trig, restart;
      trig = ce && (!m_pce || addr != m_paddr);
      restart = 0;
      m_upd = 0;
      if (m_act) begin
        if (trig && m_el > MC) begin m_el = 1; restart = 1; end
        else if (m_el == SC) begin m_act = 0; m_el = 0; m_dout = arr_data; m_upd = 1; end
        else m_el++;
      end else if (trig) begin
        m_act = 1; m_el = 1;
      end
      if (restart) m_haz = 1;
      else if (clr) m_haz = 0;
      m_pce = ce; m_paddr = addr;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 dout", dout, m_dout);
      check("R4 upd", upd, m_upd);
      check("R2 sense", sense, m_act);
      check("R6 hazard", haz, m_haz);
      check("R9 oe", doe, ce && oe && !we);
      if (upd) upd_seen++;
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #2;
    end
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 7 + 3);
    step(3);
    // R1: values held in reset
    check("R1 dout", dout, 0);
    check("R1 upd", upd, 0);
    check("R1 sense", sense, 0);
    check("R1 hazard", haz, 0);
    rst_n = 1'b1;
    step(2);

    // R3: address moves while deselected
    for (int i = 1; i < 4; i++) begin
      addr = AW'(i);
      step(1);
      check("R3 idle sense", sense, 0);
    end

    // R2: chip enable rise
    oe = 1'b1; addr = 8'd10; ce = 1'b1;
    step(1);
    check("R2 sense on", sense, 1);
    upd_seen = 0;
    step(SC + 3);
    check("R2 one update", upd_seen, 1);
    check("R4 ce data", dout, mem[10]);

    // R3: address change while selected
    addr = 8'd11;
    step(SC + 3);
    check("R3 addr data", dout, mem[11]);

    // R8: stored word changes, no trigger
    mem[11] = 8'hA5;
    step(4);
    check("R8 hold", dout, 8'd80);

    // R5: second trigger in merge window
    upd_seen = 0;
    addr = 8'd20; step(1);
    addr = 8'd21;
    step(SC + 4);
    check("R5 updates", upd_seen, 1);
    check("R5 hazard", haz, 0);
    check("R5 data", dout, mem[21]);

    // R6: late trigger
    upd_seen = 0;
    addr = 8'd30; step(3);
    addr = 8'd31;
    step(1);
    check("R6 hazard set", haz, 1);
    step(SC + 3);
    check("R6 updates", upd_seen, 1);
    check("R6 data", dout, mem[31]);

    // R7: clear, then clear racing a restart
    clr = 1'b1; step(1); clr = 1'b0;
    check("R7 cleared", haz, 0);
    addr = 8'd40; step(3);
    addr = 8'd41; clr = 1'b1;
    step(1); clr = 1'b0;
    check("R7 set wins", haz, 1);
    step(SC + 3);
    check("R7 sticky", haz, 1);
    clr = 1'b1; step(1); clr = 1'b0;

    // R9: drive enable
    we = 1'b1; step(1); check("R9 write", doe, 0);
    we = 1'b0; oe = 1'b0; step(1); check("R9 oe off", doe, 0);
    oe = 1'b1; step(1); check("R9 on", doe, 1);
    ce = 1'b0; step(1); check("R9 deselect", doe, 0);

    // R2: reselect at same address retriggers
    step(2);
    ce = 1'b1; step(1);
    check("R2 reselect", sense, 1);
    step(SC + 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule